// File: doc/BRIEF.md
# Residue-Form Adder with Range Carry

This block adds two integers in the range 0 to 20 that arrive in residue form. Each operand is given as three digits: its remainder modulo 3, its remainder modulo 7, and a single bit holding its remainder modulo 2, which for an operand below 21 is its binary parity. The modulo-3 and modulo-7 digits of the sum come from two small independent modular adders. Together they give the sum modulo 21.

The modulo-2 digits are combined by an XOR. This keeps track of the sum modulo 42. The carry needs no magnitude comparison. A small constant table gives the parity of the value that the two modulo-21 digits stand for, n1 = (7·u1 + 15·u2) mod 21. The carry is that parity XOR the modulo-2 digit of the sum. A sum below 21 has the same parity as n1. A sum from 21 to 41 has the opposite parity, because n1 is then the sum minus 21.

A caller presents both operands with a valid strobe. The sum digits, the carry and an output valid appear on registers one clock later. A caller that chains groups feeds the carry into the next group.

Top module: `rns_carry_adder`

## Requirements
- R1: A synchronous reset sets both sum digits, the carry and the output valid to 0.
- R2: One cycle after an accepted input, the 2-bit modulo-3 sum digit equals (aMod3 + bMod3) mod 3.
- R3: One cycle after an accepted input, the 3-bit modulo-7 sum digit equals (aMod7 + bMod7) mod 7.
- R4: When each operand's parity bit equals the parity of an operand value 0 to 20, the carry is 1 exactly when the sum of the two values is 21 or more.
- R5: The output valid is high in the cycle after the input valid was high, and low in the cycle after it was low.
- R6: While the input valid is low, the sum digits and the carry keep their values, whatever the operand inputs do.
- R7: The carry equals parity((7·u1 + 15·u2) mod 21) XOR aPar XOR bPar. Inverting one operand's parity bit therefore inverts the carry.
- R8: At the wrap points, a sum of exactly 21 gives digits (0, 0) with carry 1, and a sum of 20 gives digits (2, 6) with carry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operands are presented this cycle |
| opAMod3 | input | 2 | Operand A remainder modulo 3 |
| opAMod7 | input | 3 | Operand A remainder modulo 7 |
| opAPar | input | 1 | Operand A remainder modulo 2 |
| opBMod3 | input | 2 | Operand B remainder modulo 3 |
| opBMod7 | input | 3 | Operand B remainder modulo 7 |
| opBPar | input | 1 | Operand B remainder modulo 2 |
| outValid | output | 1 | Sum registers were loaded on the last edge |
| sumMod3 | output | 2 | Sum remainder modulo 3 |
| sumMod7 | output | 3 | Sum remainder modulo 7 |
| sumCarry | output | 1 | Sum reached 21 or more |

## Verification
The assertions check on every cycle that:
- each sum digit stays inside its modulus;
- the output valid follows the input valid by one cycle;
- the registers hold while nothing is loaded;
- a load whose digits and parities give a zero sum produces no carry.

Only the bench's sweeps can show the following, because they depend on the full arithmetic meaning of the digits:
- that the carry matches the magnitude of the sum for every pair of operands;
- that the digits equal the true residues;
- that a flipped parity bit inverts the carry.

// File: rtl/rns_add_pkg.sv
package rns_add_pkg;

  localparam int unsigned MOD_A = 3;
  localparam int unsigned MOD_B = 7;
  localparam int unsigned W_A = $clog2(MOD_A);
  localparam int unsigned W_B = $clog2(MOD_B);
  localparam int unsigned RANGE = MOD_A * MOD_B;
  localparam int unsigned IDX_W = $clog2(RANGE);

  typedef struct packed {
    logic clear;
    logic load;
  } strobe_t;

  // Smallest e below RANGE with e = 1 mod self and e = 0 mod other.
  function automatic int unsigned idemFor(input int unsigned self, input int unsigned other);
    int unsigned found;
    found = 0;
    for (int unsigned e = 1; e < RANGE; e++) begin
      if (found == 0 && (e % self) == 1 && (e % other) == 0) found = e;
    end
    return found;
  endfunction

  // Parity of the reconstructed value, indexed by uB*MOD_A + uA.
  function automatic logic [RANGE-1:0] buildParityTab();
    logic [RANGE-1:0] tab;
    int unsigned eA;
    int unsigned eB;
    int unsigned n;
    tab = '0;
    eA = idemFor(MOD_A, MOD_B);
    eB = idemFor(MOD_B, MOD_A);
    for (int unsigned uB = 0; uB < MOD_B; uB++) begin
      for (int unsigned uA = 0; uA < MOD_A; uA++) begin
        n = (eA * uA + eB * uB) % RANGE;
        tab[uB * MOD_A + uA] = n[0];
      end
    end
    return tab;
  endfunction

endpackage

// File: rtl/rns_mod_add.sv
module rns_mod_add #(
  parameter int unsigned MOD = 7,
  localparam int unsigned W = $clog2(MOD)
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);

  logic [W:0] rawSum;
  assign rawSum = {1'b0, a} + {1'b0, b};

  generate
    if (MOD == (1 << W) - 1) begin : g_endAround
      // Modulus 2^W-1: fold the top bit back in, then map MOD to 0.
      logic [W-1:0] folded;
      assign folded = rawSum[W-1:0] + {{(W-1){1'b0}}, rawSum[W]};
      assign sum = (folded == W'(MOD)) ? '0 : folded;
    end else begin : g_compare
      logic [W:0] reduced;
      assign reduced = rawSum - (W+1)'(MOD);
      assign sum = (rawSum >= (W+1)'(MOD)) ? reduced[W-1:0] : rawSum[W-1:0];
    end
  endgenerate

endmodule

// File: rtl/rns_add_ctrl.sv
module rns_add_ctrl
  import rns_add_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    inValid,
  output strobe_t strobes,
  output logic    outValid
);

  always_comb begin
    strobes.clear = rst;
    strobes.load  = inValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  // R5: output valid tracks input valid one cycle later
  a_r5_valid_rise: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  a_r5_valid_fall: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

endmodule

// File: rtl/rns_add_dp.sv
module rns_add_dp
  import rns_add_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  strobe_t        strobes,
  input  logic [W_A-1:0] aResA,
  input  logic [W_B-1:0] aResB,
  input  logic           aPar,
  input  logic [W_A-1:0] bResA,
  input  logic [W_B-1:0] bResB,
  input  logic           bPar,
  output logic [W_A-1:0] sumResA,
  output logic [W_B-1:0] sumResB,
  output logic           carry
);

  localparam logic [RANGE-1:0] PAR_TAB = buildParityTab();

  logic [W_A-1:0]   nextA;
  logic [W_B-1:0]   nextB;
  logic             nextPar;
  logic [IDX_W-1:0] tabIdx;
  logic             nextCarry;

  rns_mod_add #(.MOD(MOD_A)) u_addA (.a(aResA), .b(bResA), .sum(nextA));
  rns_mod_add #(.MOD(MOD_B)) u_addB (.a(aResB), .b(bResB), .sum(nextB));

  assign nextPar   = aPar ^ bPar;
  assign tabIdx    = IDX_W'(int'(nextB) * MOD_A + int'(nextA));
  assign nextCarry = PAR_TAB[tabIdx] ^ nextPar;

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      sumResA <= '0;
      sumResB <= '0;
      carry   <= 1'b0;
    end else if (strobes.load) begin
      sumResA <= nextA;
      sumResB <= nextB;
      carry   <= nextCarry;
    end
  end

  // R2: modulo-3 digit stays in range
  a_r2_digit_range: assert property (@(posedge clk) disable iff (rst)
    sumResA < W_A'(MOD_A));
  // R3: modulo-7 digit stays in range
  a_r3_digit_range: assert property (@(posedge clk) disable iff (rst)
    sumResB < W_B'(MOD_B));
  // R6: registers hold when nothing is loaded
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !strobes.load |=> $stable({sumResA, sumResB, carry}));
  // R4: a zero sum with equal parities never carries
  a_r4_zero_no_carry: assert property (@(posedge clk) disable iff (rst)
    (strobes.load && nextA == '0 && nextB == '0 && aPar == bPar) |=> !carry);

endmodule

// File: rtl/rns_carry_adder.sv
module rns_carry_adder
  import rns_add_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           inValid,
  input  logic [W_A-1:0] opAMod3,
  input  logic [W_B-1:0] opAMod7,
  input  logic           opAPar,
  input  logic [W_A-1:0] opBMod3,
  input  logic [W_B-1:0] opBMod7,
  input  logic           opBPar,
  output logic           outValid,
  output logic [W_A-1:0] sumMod3,
  output logic [W_B-1:0] sumMod7,
  output logic           sumCarry
);

  strobe_t strobes;

  rns_add_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid),
    .strobes(strobes), .outValid(outValid)
  );

  rns_add_dp u_dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .aResA(opAMod3), .aResB(opAMod7), .aPar(opAPar),
    .bResA(opBMod3), .bResB(opBMod7), .bPar(opBPar),
    .sumResA(sumMod3), .sumResB(sumMod7), .carry(sumCarry)
  );

endmodule

// File: tb/rns_carry_adder_bench.sv
module rns_carry_adder_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic [1:0] opAMod3 = '0;
  logic [2:0] opAMod7 = '0;
  logic       opAPar = 1'b0;
  logic [1:0] opBMod3 = '0;
  logic [2:0] opBMod7 = '0;
  logic       opBPar = 1'b0;
  logic       outValid;
  logic [1:0] sumMod3;
  logic [2:0] sumMod7;
  logic       sumCarry;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rns_carry_adder u_rns_carry_adder (
    .clk(clk), .rst(rst), .inValid(inValid),
    .opAMod3(opAMod3), .opAMod7(opAMod7), .opAPar(opAPar),
    .opBMod3(opBMod3), .opBMod7(opBMod7), .opBPar(opBPar),
    .outValid(outValid), .sumMod3(sumMod3), .sumMod7(sumMod7), .sumCarry(sumCarry)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int a, input int b, input bit flipA);
    opAMod3 = 2'(a % 3);
    opAMod7 = 3'(a % 7);
    opAPar  = 1'(a % 2) ^ flipA;
    opBMod3 = 2'(b % 3);
    opBMod7 = 3'(b % 7);
    opBPar  = 1'(b % 2);
  endtask

  // Present a pair at a falling edge, check it at the next falling edge.
  task automatic addPair(input int a, input int b, input bit flipA, input bit full);
    int s;
    @(negedge clk);
    drive(a, b, flipA);
    inValid = 1'b1;
    @(negedge clk);
    s = a + b;
    if (full) begin
      chk("R5 outValid", int'(outValid), 1);
      chk("R2 sumMod3", int'(sumMod3), s % 3);
      chk("R3 sumMod7", int'(sumMod7), s % 7);
    end
    if (flipA) chk("R7 inverted carry", int'(sumCarry), (s >= 21) ? 0 : 1);
    else       chk("R4 carry", int'(sumCarry), (s >= 21) ? 1 : 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1 outValid", int'(outValid), 0);
    chk("R1 sumMod3", int'(sumMod3), 0);
    chk("R1 sumMod7", int'(sumMod7), 0);
    chk("R1 carry", int'(sumCarry), 0);
    rst = 1'b0;

    // R2 R3 R4: every operand pair
    for (int a = 0; a < 21; a++)
      for (int b = 0; b < 21; b++)
        addPair(a, b, 1'b0, 1'b1);

    // R7: operand A parity digit inverted
    for (int a = 0; a < 21; a++)
      for (int b = 0; b < 21; b++)
        addPair(a, b, 1'b1, 1'b0);

    // R8: wrap boundaries
    addPair(10, 11, 1'b0, 1'b0);
    chk("R8 sum21 mod3", int'(sumMod3), 0);
    chk("R8 sum21 mod7", int'(sumMod7), 0);
    chk("R8 sum21 carry", int'(sumCarry), 1);
    addPair(20, 0, 1'b0, 1'b0);
    chk("R8 sum20 mod3", int'(sumMod3), 2);
    chk("R8 sum20 mod7", int'(sumMod7), 6);
    chk("R8 sum20 carry", int'(sumCarry), 0);

    // R6 R5: valid low, inputs change, outputs hold
    addPair(15, 17, 1'b0, 1'b1);
    @(negedge clk);
    inValid = 1'b0;
    drive(3, 4, 1'b0);
    @(negedge clk);
    chk("R5 outValid low", int'(outValid), 0);
    for (int k = 0; k < 3; k++) begin
      drive(k, 5 + k, 1'b0);
      @(negedge clk);
      chk("R6 hold mod3", int'(sumMod3), 32 % 3);
      chk("R6 hold mod7", int'(sumMod7), 32 % 7);
      chk("R6 hold carry", int'(sumCarry), 1);
    end

    // R1: reset while valid is high
    drive(20, 20, 1'b0);
    inValid = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    chk("R1 clear outValid", int'(outValid), 0);
    chk("R1 clear mod3", int'(sumMod3), 0);
    chk("R1 clear mod7", int'(sumMod7), 0);
    chk("R1 clear carry", int'(sumCarry), 0);
    rst = 1'b0;
    inValid = 1'b0;
    @(negedge clk);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule